// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block is the transmit half of an asynchronous serial port. A host writes an 8-bit or 9-bit word into a single holding register. On a baud tick the word moves into a shift register and goes out least significant bit first. A low start bit comes before the data and a high stop bit follows it. An empty flag tells the host when the holding register can take another word, and it can raise an interrupt request. Between characters the line rests at its idle level.

A send-break control makes the shifter emit all-zero characters with no start or stop bit. The character length depends on the word-length and long-break selects. Break characters repeat back to back while the control is held. Once the control is released, the character in flight completes and exactly one idle-level bit is sent before any following frame. Dropping the enable releases the pin and abandons all transmit state. A single polarity select inverts the whole line.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, and whenever the block is enabled with no character in flight, `txd_o` is 1 (with `tx_inv_i`=0) and `tx_empty_o` is 1.
- R2: In 8-bit mode (`nine_bit_i`=0) a frame is 10 bits: a 0 start bit, `wr_data_i[0]` to `wr_data_i[7]` in that order, then a 1 stop bit. Each bit occupies one baud-tick interval, and the first bit appears at the tick edge that starts the frame.
- R3: In 9-bit mode (`nine_bit_i`=1) a frame is 11 bits, with `wr_data_i[8]` sent last before the stop bit. In 8-bit mode `wr_data_i[8]` has no effect on the line.
- R4: `tx_empty_o` falls on the clock edge that accepts a write. It rises on the baud-tick edge at which the shifter takes the word.
- R5: A write while `tx_empty_o`=0 is ignored: the held word and the transmitted frame are unchanged.
- R6: `irq_o` is 1 exactly when `en_i`, `tx_ie_i` and `tx_empty_o` are all 1.
- R7: A word pending when the stop bit ends starts on that same tick, with no idle bit in between.
- R8: While `send_brk_i`=1, the shifter sends all-zero characters back to back. A character lasts 10 bit times, plus 1 if `nine_bit_i`=1, plus 1 if `long_brk_i`=1. Break has priority over a pending word.
- R9: After `send_brk_i` is cleared, the current break character completes. Exactly one bit time at 1 follows, and then the next frame, if one is pending.
- R10: While `en_i`=0, `txd_oe_o`=0, `tx_empty_o`=1, writes are ignored and any frame in flight is abandoned. After re-enable the line is idle and nothing resumes.
- R11: `tx_inv_i`=1 inverts `txd_o` in every state, idle included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low releases the pin and clears state |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| nine_bit_i | input | 1 | 1 selects 9-bit words |
| long_brk_i | input | 1 | 1 adds one bit time to break characters |
| send_brk_i | input | 1 | Hold high to send break characters |
| tx_ie_i | input | 1 | Interrupt enable for the empty flag |
| tx_inv_i | input | 1 | 1 inverts the serial output |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 9 | Word to transmit |
| tx_empty_o | output | 1 | Holding register can accept a word |
| irq_o | output | 1 | Transmit interrupt request |
| txd_o | output | 1 | Serial output |
| txd_oe_o | output | 1 | Serial pin drive enable |

## Verification
Each line bit appears on the clock edge of the baud tick that starts it. The bench raises every tick for exactly one clock and reads `txd_o` at the falling edge right after that tick's rising edge, so each read sees the bit just started. `tx_empty_o` is read at the falling edge after the write strobe's edge and again after the tick that takes the word. `irq_o` and `txd_oe_o` are combinational and are read in the same half-cycle as the input change. Break length and the single guard bit are checked by counting ticks from the first zero up to the first one.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_BRK,
    SRC_GUARD,
    SRC_DATA
  } frame_src_e;
endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  logic [WORD_W-1:0] word_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      word_q <= wr_data_i;
    end
  end

  assign word_o = word_q;
  assign full_o = full_q;
endmodule

// File: rtl/uart_brk_sel.sv
module uart_brk_sel
  import uart_brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = 4
) (
  input  logic               send_brk_i,
  input  logic               guard_owed_i,
  input  logic               full_i,
  input  logic [DATA_W:0]    word_i,
  input  logic               nine_bit_i,
  input  logic               long_brk_i,
  output frame_src_e         src_o,
  output logic [FRAME_W-1:0] bits_o,
  output logic [CNT_W-1:0]   len_o
);
  localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(DATA_W + 2);

  // priority: break, then owed guard bit, then held word
  always_comb begin
    src_o  = SRC_NONE;
    bits_o = '1;
    len_o  = '0;
    if (send_brk_i) begin
      src_o  = SRC_BRK;
      bits_o = '0;
      len_o  = BASE_LEN + CNT_W'(nine_bit_i) + CNT_W'(long_brk_i);
    end else if (guard_owed_i) begin
      src_o  = SRC_GUARD;
      bits_o = '1;
      len_o  = CNT_W'(1);
    end else if (full_i) begin
      src_o  = SRC_DATA;
      len_o  = BASE_LEN + CNT_W'(nine_bit_i);
      if (nine_bit_i) bits_o = {2'b11, word_i, 1'b0};
      else            bits_o = {3'b111, word_i[DATA_W-1:0], 1'b0};
    end
  end
endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] bits_i,
  input  logic [CNT_W-1:0]   len_i,
  output logic               busy_o,
  output logic               last_o,
  output logic               line_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!en_i) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= bits_i;
      cnt_q  <= len_i;
      busy_q <= 1'b1;
    end else if (tick_i && busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      else                    sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_W'(1));
  assign line_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            baud_tick_i,
  input  logic            nine_bit_i,
  input  logic            long_brk_i,
  input  logic            send_brk_i,
  input  logic            tx_ie_i,
  input  logic            tx_inv_i,
  input  logic            wr_i,
  input  logic [DATA_W:0] wr_data_i,
  output logic            tx_empty_o,
  output logic            irq_o,
  output logic            txd_o,
  output logic            txd_oe_o
);
  localparam int WORD_W  = DATA_W + 1;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [WORD_W-1:0]  word;
  logic               full;
  frame_src_e         src;
  logic [FRAME_W-1:0] frame_bits;
  logic [CNT_W-1:0]   frame_len;
  logic               busy, last, line;
  logic               slot_free, load, take;
  logic               guard_q;

  uart_brk_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .word_o    (word),
    .full_o    (full)
  );

  uart_brk_sel #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_sel (
    .send_brk_i   (send_brk_i),
    .guard_owed_i (guard_q),
    .full_i       (full),
    .word_i       (word),
    .nine_bit_i   (nine_bit_i),
    .long_brk_i   (long_brk_i),
    .src_o        (src),
    .bits_o       (frame_bits),
    .len_o        (frame_len)
  );

  // a new frame may start on the tick that ends the current one
  assign slot_free = baud_tick_i && (!busy || last);
  assign load      = en_i && slot_free && (src != SRC_NONE);
  assign take      = load && (src == SRC_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      guard_q <= 1'b0;
    else if (!en_i)                   guard_q <= 1'b0;
    else if (load && src == SRC_BRK)  guard_q <= 1'b1;
    else if (load && src == SRC_GUARD) guard_q <= 1'b0;
  end

  uart_brk_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (baud_tick_i),
    .load_i (load),
    .bits_i (frame_bits),
    .len_i  (frame_len),
    .busy_o (busy),
    .last_o (last),
    .line_o (line)
  );

  assign tx_empty_o = !full;
  assign irq_o      = en_i && tx_ie_i && !full;
  assign txd_o      = line ^ tx_inv_i;
  assign txd_oe_o   = en_i;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic baud_tick_i,
  input logic tx_ie_i,
  input logic tx_inv_i,
  input logic tx_empty_o,
  input logic irq_o,
  input logic txd_o
);
  AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tx_empty_o && tx_ie_i)); // R6

  AST_FULL_HOLDS_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tx_empty_o && !baud_tick_i) |=> !tx_empty_o); // R5

  AST_EMPTY_RISES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> ($past(baud_tick_i) || !$past(en_i))); // R4

  AST_LINE_STEADY_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(baud_tick_i) && $stable(tx_inv_i)) |-> $stable(txd_o)); // R2

  AST_DISABLED_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> tx_empty_o); // R10
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .baud_tick_i (baud_tick_i),
  .tx_ie_i     (tx_ie_i),
  .tx_inv_i    (tx_inv_i),
  .tx_empty_o  (tx_empty_o),
  .irq_o       (irq_o),
  .txd_o       (txd_o)
);

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       nine_bit_i = 1'b0;
  logic       long_brk_i = 1'b0;
  logic       send_brk_i = 1'b0;
  logic       tx_ie_i = 1'b0;
  logic       tx_inv_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic       tx_empty_o, irq_o, txd_o, txd_oe_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  uart_brk_tx dut (.*);

  // {nine_bit, data, expected frame LSB first, frame length}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 9'h0A5, 12'h34A, 4'd10},
    {1'b0, 9'h000, 12'h200, 4'd10},
    {1'b0, 9'h0FF, 12'h3FE, 4'd10},
    {1'b0, 9'h13C, 12'h278, 4'd10},
    {1'b1, 9'h1C3, 12'h786, 4'd11},
    {1'b1, 9'h055, 12'h4AA, 4'd11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) baud_tick_i = 1'b1;
    @(negedge clk_i) baud_tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic collect(input int n, output logic [15:0] bits);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      tick();
      bits[i] = txd_o;
    end
  endtask

  task automatic write(input logic [8:0] d);
    @(negedge clk_i) begin wr_i = 1'b1; wr_data_i = d; end
    @(negedge clk_i) wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 oe off", txd_oe_o, 0);
    check("R1 reset line", txd_o, 1);
    check("R1 reset empty", tx_empty_o, 1);
    en_i = 1'b1;
    @(negedge clk_i);
    check("R10 oe on", txd_oe_o, 1);
    check("R1 idle line", txd_o, 1);

    // table walk: R2 / R3 / R4 / R1
    for (int v = 0; v < 6; v++) begin
      logic [11:0] exp;
      int          len;
      string       tag;
      nine_bit_i = VEC[v][25];
      exp = VEC[v][15:4];
      len = int'(VEC[v][3:0]);
      tag = (VEC[v][25] || VEC[v][24]) ? "R3 bit" : "R2 bit";
      check("R4 empty before", tx_empty_o, 1);
      write(VEC[v][24:16]);
      check("R4 empty after write", tx_empty_o, 0);
      for (int i = 0; i < len; i++) begin
        tick();
        if (i == 0) check("R4 empty on take", tx_empty_o, 1);
        check(tag, txd_o, exp[i]);
      end
      tick();
      check("R1 idle after frame", txd_o, 1);
    end
    nine_bit_i = 1'b0;

    // R6
    tx_ie_i = 1'b1;
    @(negedge clk_i);
    check("R6 irq on empty", irq_o, 1);
    write(9'h011);
    check("R6 irq off when full", irq_o, 0);
    tick();
    check("R6 irq after take", irq_o, 1);
    tx_ie_i = 1'b0;
    @(negedge clk_i);
    check("R6 irq masked", irq_o, 0);
    ticks(10);

    // R5: second write ignored
    write(9'h0A5);
    write(9'h03C);
    collect(10, got);
    check("R5 frame kept", got[9:0], 10'h34A);
    tick();

    // R7: back-to-back frames
    write(9'h00F);
    tick();
    write(9'h0F0);
    ticks(9);
    tick();
    check("R7 no gap start", txd_o, 0);
    check("R7 taken", tx_empty_o, 1);
    collect(9, got);
    check("R7 second frame", got[8:0], 9'h1F0);
    tick();

    // R8 / R9: 8-bit break, two characters, pending data
    write(9'h081);
    send_brk_i = 1'b1;
    collect(10, got);
    check("R8 break char 1", got[9:0], 10'h000);
    check("R8 break priority", tx_empty_o, 0);
    collect(4, got);
    send_brk_i = 1'b0;
    collect(6, got);
    check("R9 break completes", {got[5:0]}, 6'h00);
    tick();
    check("R9 guard bit", txd_o, 1);
    tick();
    check("R9 data after guard", txd_o, 0);
    check("R9 data taken", tx_empty_o, 1);
    collect(9, got);
    check("R9 data frame", got[8:0], 9'h181);
    tick();

    // R8: 8-bit long break = 11
    long_brk_i = 1'b1;
    send_brk_i = 1'b1;
    tick();
    send_brk_i = 1'b0;
    collect(10, got);
    check("R8 long 8-bit zeros", got[9:0], 10'h000);
    tick();
    check("R8 long 8-bit end", txd_o, 1);
    tick();

    // R8: 9-bit long break = 12
    nine_bit_i = 1'b1;
    send_brk_i = 1'b1;
    collect(5, got);
    send_brk_i = 1'b0;
    collect(7, got);
    check("R8 long 9-bit zeros", got[6:0], 7'h00);
    tick();
    check("R8 long 9-bit end", txd_o, 1);
    tick();
    check("R9 idle after guard", txd_o, 1);
    nine_bit_i = 1'b0;
    long_brk_i = 1'b0;

    // R10
    write(9'h000);
    ticks(2);
    en_i = 1'b0;
    @(negedge clk_i);
    check("R10 oe released", txd_oe_o, 0);
    check("R10 empty when off", tx_empty_o, 1);
    write(9'h055);
    en_i = 1'b1;
    @(negedge clk_i);
    check("R10 write ignored", tx_empty_o, 1);
    check("R10 idle on return", txd_o, 1);
    tick();
    check("R10 nothing resumes", txd_o, 1);

    // R11
    tx_inv_i = 1'b1;
    @(negedge clk_i);
    check("R11 idle inverted", txd_o, 0);
    write(9'h0A5);
    collect(10, got);
    check("R11 frame inverted", got[9:0], 10'h0B5);
    tick();
    check("R11 idle after", txd_o, 0);
    tx_inv_i = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule